// File: doc/BRIEF.md
# UART Transmitter with Automatic CTS Pacing

This block is the transmit half of a serial port. Bytes arrive on a valid/ready write stream and wait in storage. Storage is either a one-entry holding register or a transmit FIFO, chosen by a mode pin. A shift register then sends each byte as an asynchronous frame on the serial line. The frame has one start bit, eight data bits sent least significant bit first, and one stop bit. Each bit lasts a fixed number of one-cycle baud-tick pulses.

Automatic flow control can be switched on with two enable pins, and it takes effect only when both are set. When it is active, the active-low clear-to-send input is consulted only at the moment the next byte would move into the shift register. A high level on that input blocks the move. The character already on the line always finishes, stop bit included. The line then rests at mark, and queued bytes stay in storage until the input drops low again.

Back-pressure rules: a byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while storage is at its capacity. Any `wr_valid` pulse that meets a low `wr_ready` and is withdrawn is discarded and never sent.

Top module: `uart_tx_flow`

## Requirements
- R1: Storage holds 1 byte when `fifo_en`=0 and DEPTH (16) bytes when `fifo_en`=1. `wr_ready` is low exactly when storage is at that capacity. A write offered while `wr_ready` is low is discarded.
- R2: The idle line is 1. A frame is a 0 start bit, then data bit 0 through bit 7, then a 1 stop bit, and each bit lasts 16 `baud_tick` pulses.
- R3: Bytes leave the block in the order they were accepted.
- R4: `tx_empty` is 1 out of reset. It drops on the clock edge that accepts a write. It is 1 only when storage is empty and no character is being shifted.
- R5: When `fifo_en`=1, `tx_empty` stays 0 while any byte remains in the FIFO, even between characters.
- R6: Flow control is active only when `auto_cts_en`=1 and `rts_cts_sel`=1. With either pin at 0, `cts_n` has no effect.
- R7: With flow control active, `cts_n`=1 prevents a new character from starting. A character already started still completes through its stop bit.
- R8: While blocked with data pending, `tx_halted`=1, `txd` stays 1, `tx_empty` stays 0, and the pending bytes are kept.
- R9: When `cts_n` returns to 0, the pending bytes are sent without loss.
- R10: During a character, `txd` changes only on a clock edge where `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write stream valid |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Storage can take a byte |
| baud_tick | input | 1 | One-cycle pulse; 16 per bit |
| cts_n | input | 1 | Clear-to-send, active low, already synchronized |
| fifo_en | input | 1 | 1 selects the FIFO, 0 selects the holding register |
| auto_cts_en | input | 1 | Automatic CTS enable |
| rts_cts_sel | input | 1 | RTS/CTS flow-control select |
| txd | output | 1 | Serial line |
| tx_empty | output | 1 | Storage and shifter both empty |
| tx_halted | output | 1 | Data pending but blocked by CTS |

## Verification
An accepted write clears `tx_empty` on that same edge. If the byte is not blocked, its start bit appears one edge later, and every later bit boundary comes 16 ticks after the previous one. The bench drives inputs and samples outputs on falling clock edges. It pulses `baud_tick` every second cycle, so one bit lasts 32 cycles. A line monitor waits 16 cycles after each falling start edge and then samples at 32-cycle steps, which puts every sample in the middle of a bit. Halting is judged over a window longer than two frames, and the check that nothing was sent is made before `cts_n` is released.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // framing overhead around the data bits
  localparam int START_BITS = 1;
  localparam int STOP_BITS  = 1;

  typedef struct packed {
    logic auto_en;
    logic flow_sel;
  } flow_cfg_t;

  function automatic logic flow_active(input flow_cfg_t cfg);
    return cfg.auto_en & cfg.flow_sel;
  endfunction
endpackage

// File: rtl/uart_tx_store.sv
module uart_tx_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop, at_cap;

  // holding-register mode is the same array limited to one entry
  assign at_cap     = fifo_en ? (level == CW'(DEPTH)) : (level != '0);
  assign push_ready = ~at_cap;
  assign do_push    = push_valid & push_ready;
  assign do_pop     = pop & (level != '0);
  assign pop_data   = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_gate.sv
module uart_tx_gate
  import uart_tx_pkg::*;
(
  input  flow_cfg_t cfg,
  input  logic      cts_n,
  input  logic      shifter_busy,
  input  logic      pending,
  output logic      load,
  output logic      halted
);
  logic block;

  // consulted only when the shifter is free to take the next byte
  assign block  = flow_active(cfg) & cts_n;
  assign load   = ~shifter_busy & pending & ~block;
  assign halted = ~shifter_busy & pending & block;
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  localparam int FW = DATA_W + START_BITS + STOP_BITS,
  localparam int BW = $clog2(FW),
  localparam int TW = $clog2(TICKS_PER_BIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              txd
);
  logic [FW-1:0] frame;
  logic [BW-1:0] bit_no;
  logic [TW-1:0] tick_no;

  assign txd = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '1;
      bit_no  <= '0;
      tick_no <= '0;
      busy    <= 1'b0;
    end else if (load && !busy) begin
      frame   <= {{STOP_BITS{1'b1}}, load_data, {START_BITS{1'b0}}};
      bit_no  <= '0;
      tick_no <= '0;
      busy    <= 1'b1;
    end else if (busy && tick) begin
      if (tick_no == TW'(TICKS_PER_BIT - 1)) begin
        tick_no <= '0;
        if (bit_no == BW'(FW - 1)) begin
          busy <= 1'b0;
        end else begin
          bit_no <= bit_no + BW'(1);
          frame  <= {1'b1, frame[FW-1:1]};
        end
      end else begin
        tick_no <= tick_no + TW'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              baud_tick,
  input  logic              cts_n,
  input  logic              fifo_en,
  input  logic              auto_cts_en,
  input  logic              rts_cts_sel,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_halted
);
  logic [CW-1:0]     level;
  logic [DATA_W-1:0] head;
  logic              busy, load;
  flow_cfg_t         cfg;

  assign cfg.auto_en  = auto_cts_en;
  assign cfg.flow_sel = rts_cts_sel;

  uart_tx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push_valid(wr_valid), .push_data(wr_data), .push_ready(wr_ready),
    .pop(load), .pop_data(head), .level(level)
  );

  uart_tx_gate u_gate (
    .cfg(cfg), .cts_n(cts_n), .shifter_busy(busy),
    .pending(level != '0), .load(load), .halted(tx_halted)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load),
    .load_data(head), .busy(busy), .txd(txd)
  );

  assign tx_empty = (level == '0) & ~busy;
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          baud_tick,
  input logic          cts_n,
  input logic          auto_cts_en,
  input logic          rts_cts_sel,
  input logic          txd,
  input logic          tx_empty,
  input logic          tx_halted,
  input logic          busy,
  input logic [CW-1:0] level
);
  p_level_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) == DEPTH) |-> !wr_ready);

  p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_accept_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tx_empty);

  p_no_start_when_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !($past(auto_cts_en) && $past(rts_cts_sel) && $past(cts_n)));

  p_halt_holds_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_halted |-> (txd && !tx_empty));

  p_tick_paced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(baud_tick)) |-> $stable(txd));
endmodule

bind uart_tx_flow uart_tx_flow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .baud_tick(baud_tick), .cts_n(cts_n), .auto_cts_en(auto_cts_en),
  .rts_cts_sel(rts_cts_sel), .txd(txd), .tx_empty(tx_empty),
  .tx_halted(tx_halted), .busy(busy), .level(level)
);

// File: tb/test_uart_tx_flow.sv
`timescale 1ns/1ps
module test_uart_tx_flow;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, baud_tick = 0, cts_n = 0;
  logic fifo_en = 0, auto_cts_en = 0, rts_cts_sel = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, txd, tx_empty, tx_halted;

  int checks = 0, errors = 0;
  bit finished = 0;

  // line monitor state
  logic [7:0] rx_mem [0:63];
  int rx_n = 0, rx_bad = 0, rx_t = 0;
  bit rx_on = 0, rx_prev = 1;
  logic [7:0] rx_sh = 0;

  uart_tx_flow i_uart_tx_flow (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .baud_tick(baud_tick), .cts_n(cts_n),
    .fifo_en(fifo_en), .auto_cts_en(auto_cts_en), .rts_cts_sel(rts_cts_sel),
    .txd(txd), .tx_empty(tx_empty), .tx_halted(tx_halted)
  );

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
  end

  // one bit = 16 ticks = 32 cycles; sample mid-bit
  always @(negedge clk) begin
    if (!rst_n) begin
      rx_on = 0;
      rx_prev = 1;
    end else begin
      if (!rx_on) begin
        if (rx_prev && !txd) begin
          rx_on = 1;
          rx_t = 0;
        end
      end else begin
        rx_t++;
        if (rx_t == 16) begin
          if (txd !== 1'b0) rx_bad++;
        end else if (rx_t > 16 && rx_t < 16 + 32 * 9 && (rx_t - 16) % 32 == 0) begin
          rx_sh[(rx_t - 16) / 32 - 1] = txd;
        end else if (rx_t == 16 + 32 * 9) begin
          if (txd !== 1'b1) rx_bad++;
          if (rx_n < 64) rx_mem[rx_n] = rx_sh;
          rx_n++;
          rx_on = 0;
        end
      end
      rx_prev = txd;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1;
    wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic offer_blocked(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1;
    wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_empty && !rx_on)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_bytes(input int base, input int n, input logic [7:0] e [16], input string req);
    check(rx_n == base + n, req, rx_n - base, n);
    for (int i = 0; i < n; i++)
      if (base + i < rx_n)
        check(rx_mem[base + i] == e[i], req, rx_mem[base + i], e[i]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(txd == 1, "R2 idle line", txd, 1);
    check(tx_empty == 1, "R4 empty after reset", tx_empty, 1);
    check(wr_ready == 1, "R1 ready after reset", wr_ready, 1);
    check(tx_halted == 0, "R8 not halted after reset", tx_halted, 0);
  endtask

  task automatic t_holding();
    logic [7:0] e [16];
    int base = rx_n;
    fifo_en = 0; auto_cts_en = 0; rts_cts_sel = 0; cts_n = 0;
    e[0] = 8'hA5; e[1] = 8'h3C;
    push(8'hA5);
    check(tx_empty == 0, "R4 empty drops on accept", tx_empty, 0);
    push(8'h3C);
    check(wr_ready == 0, "R1 holding register full", wr_ready, 0);
    offer_blocked(8'hFF);
    wait_idle();
    expect_bytes(base, 2, e, "R1 R2 holding mode bytes");
    check(tx_empty == 1, "R4 empty after frames", tx_empty, 1);
  endtask

  task automatic t_fifo_halt();
    logic [7:0] e [16];
    int base = rx_n;
    bit line_low = 0;
    fifo_en = 1; auto_cts_en = 1; rts_cts_sel = 1; cts_n = 1;
    for (int i = 0; i < 16; i++) begin
      e[i] = 8'(i * 17 + 3);
      push(e[i]);
    end
    check(wr_ready == 0, "R1 fifo full at 16", wr_ready, 0);
    check(tx_halted == 1, "R8 halted flag", tx_halted, 1);
    check(tx_empty == 0, "R5 empty low with fifo data", tx_empty, 0);
    offer_blocked(8'hEE);
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) line_low = 1;
    end
    check(!line_low, "R8 line held at mark", line_low, 0);
    check(rx_n == base, "R8 nothing sent while blocked", rx_n - base, 0);
    cts_n = 0;
    wait_idle();
    expect_bytes(base, 16, e, "R3 R9 fifo order after release");
    check(tx_halted == 0, "R9 halt cleared", tx_halted, 0);
  endtask

  task automatic t_mid_char();
    logic [7:0] e [16];
    int base = rx_n;
    fifo_en = 1; auto_cts_en = 1; rts_cts_sel = 1; cts_n = 0;
    e[0] = 8'h11; e[1] = 8'h22; e[2] = 8'h33;
    push(8'h11); push(8'h22); push(8'h33);
    while (txd !== 1'b0) @(negedge clk);
    repeat (40) @(negedge clk);
    cts_n = 1;
    repeat (800) @(negedge clk);
    check(rx_n == base + 1, "R7 current char completes only", rx_n - base, 1);
    if (rx_n > base) check(rx_mem[base] == 8'h11, "R7 completed char", rx_mem[base], 8'h11);
    check(tx_halted == 1 && txd == 1, "R8 halted at boundary", {tx_halted, txd}, 2'b11);
    check(tx_empty == 0, "R5 empty low while halted", tx_empty, 0);
    cts_n = 0;
    wait_idle();
    expect_bytes(base, 3, e, "R9 remaining chars sent");
  endtask

  task automatic t_gate_needs_both();
    logic [7:0] e [16];
    int base = rx_n;
    fifo_en = 1; cts_n = 1;
    auto_cts_en = 1; rts_cts_sel = 0;
    e[0] = 8'h5A; e[1] = 8'hC3;
    push(8'h5A);
    wait_idle();
    auto_cts_en = 0; rts_cts_sel = 1;
    push(8'hC3);
    wait_idle();
    expect_bytes(base, 2, e, "R6 cts ignored unless both enables");
    cts_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_holding();
    t_fifo_halt();
    t_mid_char();
    t_gate_needs_both();
    check(rx_bad == 0, "R2 start/stop bit levels", rx_bad, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule